// File: doc/BRIEF.md
# Delegating Interrupt Pending Arbiter

This block decides which local interrupt a hart takes next, if any. It holds the pending register and a claim register. It combines the pending bits with an enable vector, a delegation vector, the current privilege level and two global interrupt-enable bits. The result is a take flag and the cause number of the winning interrupt.

Each candidate is gated by one of two enables. A bit with a clear delegation bit stays at machine level and needs the machine-level enable. A bit with a set delegation bit is routed to supervisor level and needs the supervisor-level enable. Among the bits that survive this gating, the lowest-numbered bit wins.

The pending register is changed through a masked merge. The merge returns the contents the register held before the write. The claim register reserves pending bit positions for one hardware owner. A claim is rejected as a whole if it touches a position that is already reserved.

Top module: `irq_pick_unit`

## Requirements
- R1: After reset the pending register and the claim register are all zeros, and the take flag is low.
- R2: A merge request with mask M and value V leaves the pending register equal to (old AND NOT M) OR (V AND M) in the following cycle. Without a request the pending register keeps its value.
- R3: During the cycle of a merge request, `upd_old` shows the pending contents from before the merge.
- R4: Only bits that are set in both the pending register and `en_mask` can be taken. With `en_mask` all zeros, no interrupt is taken.
- R5: Privilege is encoded as 0 = user, 1 = supervisor, 3 = machine. A bit whose `deleg_mask` bit is 0 can be taken when the privilege is below 3, or when the privilege is 3 and `mie_bit` is 1.
- R6: A bit whose `deleg_mask` bit is 1 can be taken when the privilege is 0, or when the privilege is 1 and `sie_bit` is 1. At privilege 2 or 3 it is never taken.
- R7: When one or more bits survive the gating, `take_irq` is 1 and `irq_cause` is the index of the lowest surviving bit.
- R8: When no bit survives, `take_irq` is 0 and `irq_cause` is 0.
- R9: A claim whose bits overlap the claim register returns `clm_ok` = 0 and leaves the claim register unchanged.
- R10: A claim with no overlap returns `clm_ok` = 1 in the request cycle. The requested bits are ORed into the claim register in the next cycle.
- R11: A merge request and a claim request in the same cycle are both applied, and both results are visible in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_mask | input | 16 | Per-bit interrupt enable |
| deleg_mask | input | 16 | Per-bit delegation to supervisor level |
| priv | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| mie_bit | input | 1 | Machine global interrupt enable |
| sie_bit | input | 1 | Supervisor global interrupt enable |
| upd_valid | input | 1 | Pending merge request |
| upd_mask | input | 16 | Bits to replace in the pending register |
| upd_value | input | 16 | Replacement values |
| upd_old | output | 16 | Pending contents before the merge |
| clm_valid | input | 1 | Claim request |
| clm_bits | input | 16 | Bit positions to reserve |
| clm_ok | output | 1 | Claim accepted |
| clm_state | output | 16 | Current claim register |
| pend_state | output | 16 | Current pending register |
| take_irq | output | 1 | An interrupt should be taken |
| irq_cause | output | 4 | Index of the winning interrupt |

## Verification
The arbiter result, `upd_old` and `clm_ok` are combinational. The bench drives these inputs at a falling edge and samples the outputs 1 ns later, in the same cycle. The pending and claim registers change at the next rising edge. The bench therefore reads `pend_state` and `clm_state` at the falling edge that follows the request, one cycle after it. Arbiter results that depend on a new pending value are sampled only after that write has landed.

// File: rtl/irq_pick_pkg.sv
package irq_pick_pkg;
   typedef enum logic [1:0] {
      PRIV_USER = 2'd0,
      PRIV_SUPV = 2'd1,
      PRIV_RSVD = 2'd2,
      PRIV_MACH = 2'd3
   } priv_e;

   function automatic logic mach_gate(input priv_e pv, input logic mie);
      return (pv != PRIV_MACH) || mie;
   endfunction

   function automatic logic supv_gate(input priv_e pv, input logic sie);
      return (pv == PRIV_USER) || ((pv == PRIV_SUPV) && sie);
   endfunction
endpackage

// File: rtl/irq_pend_store.sv
module irq_pend_store #(
   parameter int N = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         upd_valid_i,
   input  logic [N-1:0] upd_mask_i,
   input  logic [N-1:0] upd_value_i,
   output logic [N-1:0] upd_old_o,
   output logic [N-1:0] pend_o
);
   logic [N-1:0] pend_q;
   logic [N-1:0] merged;

   if (N < 1) begin : g_bad_n
      $error("irq_pend_store: N must be positive");
   end

   always_comb begin
      merged = (pend_q & ~upd_mask_i) | (upd_value_i & upd_mask_i);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else if (upd_valid_i) pend_q <= merged;
   end

   assign upd_old_o = pend_q;
   assign pend_o    = pend_q;

   AST_PEND_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid_i |=> pend_q == (($past(upd_old_o) & ~$past(upd_mask_i)) |
                                 ($past(upd_value_i) & $past(upd_mask_i)))); // R2
   AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_valid_i |=> $stable(pend_q)); // R2
endmodule

// File: rtl/irq_claim_store.sv
module irq_claim_store #(
   parameter int N = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clm_valid_i,
   input  logic [N-1:0] clm_bits_i,
   output logic         clm_ok_o,
   output logic [N-1:0] claim_o
);
   logic [N-1:0] claim_q;
   logic         clash;

   if (N < 1) begin : g_bad_n
      $error("irq_claim_store: N must be positive");
   end

   assign clash    = |(claim_q & clm_bits_i);
   assign clm_ok_o = clm_valid_i && !clash;

   always_ff @(posedge clk) begin
      if (!rst_n) claim_q <= '0;
      else if (clm_valid_i && !clash) claim_q <= claim_q | clm_bits_i;
   end

   assign claim_o = claim_q;

   AST_CLM_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (clm_valid_i && !clm_ok_o) |=> $stable(claim_q)); // R9
   AST_CLM_GROW: assert property (@(posedge clk) disable iff (!rst_n)
      clm_ok_o |=> ((claim_q & $past(clm_bits_i)) == $past(clm_bits_i))); // R10
   AST_CLM_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(claim_q) & ~claim_q) == '0)); // R10
endmodule

// File: rtl/irq_gate.sv
module irq_gate
   import irq_pick_pkg::*;
#(
   parameter int N = 16
) (
   input  logic [N-1:0] pend_i,
   input  logic [N-1:0] en_i,
   input  logic [N-1:0] deleg_i,
   input  logic [1:0]   priv_i,
   input  logic         mie_i,
   input  logic         sie_i,
   output logic [N-1:0] cand_o
);
   priv_e pv;
   logic  m_ok;
   logic  s_ok;

   assign pv   = priv_e'(priv_i);
   assign m_ok = mach_gate(pv, mie_i);
   assign s_ok = supv_gate(pv, sie_i);

   for (genvar b = 0; b < N; b++) begin : g_bit
      logic armed;
      assign armed     = pend_i[b] & en_i[b];
      assign cand_o[b] = armed & (deleg_i[b] ? s_ok : m_ok);
   end
endmodule

// File: rtl/irq_lsb_pick.sv
module irq_lsb_pick #(
   parameter int N          = 16,
   parameter int PICK_STYLE = 0,
   localparam int CW        = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  vec_i,
   output logic          any_o,
   output logic [CW-1:0] idx_o
);
   if (PICK_STYLE != 0 && PICK_STYLE != 1) begin : g_bad_style
      $error("irq_lsb_pick: PICK_STYLE must be 0 or 1");
   end

   assign any_o = |vec_i;

   if (PICK_STYLE == 0) begin : g_scan
      always_comb begin
         idx_o = '0;
         for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = CW'(i);
         end
      end
   end else begin : g_onehot
      logic [N-1:0] lone;
      assign lone = vec_i & (~vec_i + N'(1));
      for (genvar j = 0; j < CW; j++) begin : g_enc
         logic [N-1:0] sel;
         for (genvar i = 0; i < N; i++) begin : g_sel
            assign sel[i] = lone[i] & ((i >> j) & 1) != 0;
         end
         assign idx_o[j] = |sel;
      end
   end
endmodule

// File: rtl/irq_pick_unit.sv
module irq_pick_unit #(
   parameter int N          = 16,
   parameter int PICK_STYLE = 0,
   localparam int CW        = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  en_mask,
   input  logic [N-1:0]  deleg_mask,
   input  logic [1:0]    priv,
   input  logic          mie_bit,
   input  logic          sie_bit,
   input  logic          upd_valid,
   input  logic [N-1:0]  upd_mask,
   input  logic [N-1:0]  upd_value,
   output logic [N-1:0]  upd_old,
   input  logic          clm_valid,
   input  logic [N-1:0]  clm_bits,
   output logic          clm_ok,
   output logic [N-1:0]  clm_state,
   output logic [N-1:0]  pend_state,
   output logic          take_irq,
   output logic [CW-1:0] irq_cause
);
   logic [N-1:0] pend_w;
   logic [N-1:0] cand_w;

   if (N < 2 || N > 64) begin : g_bad_n
      $error("irq_pick_unit: N out of range 2..64");
   end

   irq_pend_store #(.N(N)) u_pend (
      .clk(clk), .rst_n(rst_n),
      .upd_valid_i(upd_valid), .upd_mask_i(upd_mask), .upd_value_i(upd_value),
      .upd_old_o(upd_old), .pend_o(pend_w)
   );

   irq_claim_store #(.N(N)) u_claim (
      .clk(clk), .rst_n(rst_n),
      .clm_valid_i(clm_valid), .clm_bits_i(clm_bits),
      .clm_ok_o(clm_ok), .claim_o(clm_state)
   );

   irq_gate #(.N(N)) u_gate (
      .pend_i(pend_w), .en_i(en_mask), .deleg_i(deleg_mask),
      .priv_i(priv), .mie_i(mie_bit), .sie_i(sie_bit), .cand_o(cand_w)
   );

   irq_lsb_pick #(.N(N), .PICK_STYLE(PICK_STYLE)) u_pick (
      .vec_i(cand_w), .any_o(take_irq), .idx_o(irq_cause)
   );

   assign pend_state = pend_w;

   AST_TAKE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      take_irq |-> (pend_w[irq_cause] && en_mask[irq_cause])); // R4
   AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      take_irq |-> ((cand_w & ((N'(1) << irq_cause) - N'(1))) == '0)); // R7
   AST_IDLE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      !take_irq |-> (irq_cause == '0)); // R8
   AST_DELEG_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (take_irq && priv[1]) |-> !deleg_mask[irq_cause]); // R6
   AST_MACH_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (take_irq && priv == 2'd3 && !mie_bit) |-> 1'b0); // R5
endmodule

// File: tb/tb_irq_pick_unit.sv
`timescale 1ns/1ps
module tb_irq_pick_unit;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] en_mask, deleg_mask, upd_mask, upd_value, clm_bits;
   logic [1:0]  priv;
   logic        mie_bit, sie_bit, upd_valid, clm_valid;
   logic [15:0] upd_old, clm_state, pend_state;
   logic        clm_ok, take_irq;
   logic [3:0]  irq_cause;

   int n_chk = 0;
   int n_bad = 0;
   logic [15:0] exp_pend, exp_claim;

   always #2.5 clk = ~clk;

   irq_pick_unit dut (
      .clk(clk), .rst_n(rst_n), .en_mask(en_mask), .deleg_mask(deleg_mask),
      .priv(priv), .mie_bit(mie_bit), .sie_bit(sie_bit),
      .upd_valid(upd_valid), .upd_mask(upd_mask), .upd_value(upd_value),
      .upd_old(upd_old), .clm_valid(clm_valid), .clm_bits(clm_bits),
      .clm_ok(clm_ok), .clm_state(clm_state), .pend_state(pend_state),
      .take_irq(take_irq), .irq_cause(irq_cause)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [4:0] model(input logic [15:0] p, e, d,
                                         input logic [1:0] pv, input logic m, s);
      logic m_ok, s_ok;
      logic [15:0] surv;
      m_ok = (pv != 2'd3) || m;
      s_ok = (pv == 2'd0) || (pv == 2'd1 && s);
      surv = p & e & ((~d & {16{m_ok}}) | (d & {16{s_ok}}));
      for (int i = 0; i < 16; i++) if (surv[i]) return {1'b1, 4'(i)};
      return 5'b0;
   endfunction

   task automatic merge(input logic [15:0] m, input logic [15:0] v);
      @(negedge clk);
      upd_valid = 1'b1; upd_mask = m; upd_value = v;
      #1 check("R3 upd_old", upd_old, exp_pend);
      @(posedge clk);
      @(negedge clk);
      upd_valid = 1'b0;
      exp_pend = (exp_pend & ~m) | (v & m);
      check("R2 pend_state", pend_state, exp_pend);
   endtask

   task automatic arb(input string tag, input logic [15:0] e, d,
                      input logic [1:0] pv, input logic m, s);
      logic [4:0] x;
      @(negedge clk);
      en_mask = e; deleg_mask = d; priv = pv; mie_bit = m; sie_bit = s;
      x = model(exp_pend, e, d, pv, m, s);
      #1;
      check({tag, " take"}, take_irq, x[4]);
      check({tag, " cause"}, irq_cause, x[3:0]);
   endtask

   task automatic claim(input string tag, input logic [15:0] b, input logic ok);
      @(negedge clk);
      clm_valid = 1'b1; clm_bits = b;
      #1 check({tag, " clm_ok"}, clm_ok, ok);
      @(posedge clk);
      @(negedge clk);
      clm_valid = 1'b0;
      if (ok) exp_claim = exp_claim | b;
      check({tag, " clm_state"}, clm_state, exp_claim);
   endtask

   task automatic t_reset();
      check("R1 pend", pend_state, 16'h0);
      check("R1 claim", clm_state, 16'h0);
      check("R1 take", take_irq, 1'b0);
   endtask

   task automatic t_merge();
      merge(16'hFFFF, 16'hA5A5);
      merge(16'h00F0, 16'h0F0F);
      merge(16'h0000, 16'hFFFF);
      merge(16'h8001, 16'h0001);
   endtask

   task automatic t_gating();
      // pending now 0x2505
      arb("R4 none enabled", 16'h0000, 16'h0000, 2'd0, 1'b1, 1'b1);
      arb("R4 one enabled", 16'h0100, 16'h0000, 2'd0, 1'b0, 1'b0);
      arb("R5 mach masked", 16'hFFFF, 16'h0000, 2'd3, 1'b0, 1'b1);
      arb("R5 mach open", 16'hFFFF, 16'h0000, 2'd3, 1'b1, 1'b0);
      arb("R5 supv below mach", 16'hFFFF, 16'h0000, 2'd1, 1'b0, 1'b0);
      arb("R6 deleg in mach", 16'hFFFF, 16'hFFFF, 2'd3, 1'b1, 1'b1);
      arb("R6 deleg supv off", 16'hFFFF, 16'hFFFF, 2'd1, 1'b1, 1'b0);
      arb("R6 deleg supv on", 16'hFFFF, 16'hFFFF, 2'd1, 1'b0, 1'b1);
      arb("R6 deleg user", 16'hFFFF, 16'hFFFF, 2'd0, 1'b0, 1'b0);
      arb("R6 deleg rsvd", 16'hFFFF, 16'hFFFF, 2'd2, 1'b1, 1'b1);
      arb("R7 skip deleg bit0", 16'hFFFF, 16'h0001, 2'd3, 1'b1, 1'b1);
      arb("R7 lowest", 16'hFFFF, 16'h0000, 2'd0, 1'b0, 1'b0);
      arb("R8 no survivor", 16'h0002, 16'h0000, 2'd0, 1'b1, 1'b1);
      for (int pv = 0; pv < 4; pv++)
         for (int ms = 0; ms < 4; ms++)
            arb("R7 sweep", 16'hFFF0, 16'h0500, 2'(pv), ms[0], ms[1]);
   endtask

   task automatic t_claim();
      claim("R10 first", 16'h0003, 1'b1);
      claim("R9 overlap", 16'h0006, 1'b0);
      claim("R10 second", 16'h0030, 1'b1);
      claim("R9 full overlap", 16'h0010, 1'b0);
   endtask

   task automatic t_both();
      @(negedge clk);
      upd_valid = 1'b1; upd_mask = 16'hFF00; upd_value = 16'h1200;
      clm_valid = 1'b1; clm_bits = 16'h0400;
      #1;
      check("R11 upd_old", upd_old, exp_pend);
      check("R11 clm_ok", clm_ok, 1'b1);
      @(posedge clk);
      @(negedge clk);
      upd_valid = 1'b0; clm_valid = 1'b0;
      exp_pend = (exp_pend & 16'h00FF) | 16'h1200;
      exp_claim = exp_claim | 16'h0400;
      check("R11 pend", pend_state, exp_pend);
      check("R11 claim", clm_state, exp_claim);
      arb("R7 after merge", 16'hFF00, 16'h0000, 2'd0, 1'b0, 1'b0);
   endtask

   initial begin
      #1_000_000;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; en_mask = '0; deleg_mask = '0; priv = 2'd3;
      mie_bit = 1'b0; sie_bit = 1'b0; upd_valid = 1'b0; upd_mask = '0;
      upd_value = '0; clm_valid = 1'b0; clm_bits = '0;
      exp_pend = '0; exp_claim = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_merge();
      t_gating();
      t_claim();
      t_both();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end
endmodule